// File: doc/BRIEF.md
# Dual-Rail Fixpoint Evaluator for a Cross-Coupled Pair

This block settles a two-signal combinational loop, X = I and not Y together with Y = J and not X, without ever guessing a value. Each of X and Y is held as a pair of flags: a "true" flag that is set once the value 1 has been proved, and a "false" flag that is set once the value 0 has been proved. With neither flag set the value is unknown. The pair is computed with three-valued logic, one step per clock, until a step changes nothing.

A caller drives the two binary inputs and pulses `start`. The block captures the inputs and clears both flags of X and Y. It then steps the flag equations on every clock edge. When a step leaves every flag unchanged, the block raises `done`. It also reports `constructive` when both X and Y have exactly one flag set. Inputs for which no proof exists, such as both inputs high, leave X and Y unknown and `constructive` low. The results stay on the outputs until the next accepted start.

Top module: `dr_loop_eval`

## Requirements
- R1: After a synchronous active-low reset, all four X/Y flags, `busy`, `done`, `constructive` and `rail_err` are 0.
- R2: A value is encoded as a flag pair: only the true flag set means 1, only the false flag set means 0, and neither set means unknown. On the clock edge that accepts `start`, the inputs are captured, all X/Y flags are cleared and `busy` rises.
- R3: While busy, all flags update together on each edge from the previous values: X.true <= I and Y.false, X.false <= (not I) or Y.true, Y.true <= J and X.false, Y.false <= (not J) or X.true.
- R4: Between two accepted starts, a flag that has been set never clears. A value is only ever added by proof.
- R5: With I=0 and J=1 the result is X=0 and Y=1, and `constructive` is 1.
- R6: With I=1 and J=0 the result is X=1 and Y=0, and `constructive` is 1.
- R7: With I=1 and J=1 both X and Y stay unknown, and `constructive` is 0 while `done` is 1.
- R8: `done` rises on the edge of the first step that changes no flag. This is three edges after the accepting edge for (0,1) and (1,0), two for (0,0) and one for (1,1). `done`, `constructive` and the flags then hold until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored: the captured inputs and the step sequence are unaffected.
- R10: `rail_err` is high whenever a signal has both flags set. On a correct evaluation it is never high.
- R11: With I=0 and J=0 the result is X=0 and Y=0, and `constructive` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; accepted when not busy |
| in_i | input | 1 | Binary input feeding X |
| in_j | input | 1 | Binary input feeding Y |
| x_t | output | 1 | X proved true |
| x_f | output | 1 | X proved false |
| y_t | output | 1 | Y proved true |
| y_f | output | 1 | Y proved false |
| busy | output | 1 | Stepping in progress |
| done | output | 1 | Fixpoint reached; results valid |
| constructive | output | 1 | Done and every signal resolved |
| rail_err | output | 1 | A signal has both flags set |

## Verification
The assertions assume that `in_i` and `in_j` matter only on the edge where a start is accepted. They also assume that reset is held for at least one edge before the first start. The bench keeps to this by changing the inputs only together with a start pulse, or during a run, where their changes must have no effect. It applies reset for several cycles before the first stimulus. A behavioural model steps the three-valued values with integer codes and is compared with the flags on every clock. Start pulses are sent while idle, while done, and in the middle of a run.

// File: rtl/dr_pkg.sv
// Package: shared types for the dual-rail loop evaluator.
// Assumes: two loop signals; a value is a pair of proof flags.
package dr_pkg;
    localparam int NSIG = 2;

    // One three-valued value: t = proved 1, f = proved 0, none = unknown.
    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ev_state_e;
endpackage

// File: rtl/dr_rail_cell.sv
// Module: one "in AND NOT opp" gate in dual-rail form.
// What it does: derives the next proof flags of a loop signal from its
// binary input and the current flags of the opposing signal.
// Assumes: the input is binary, so its own rails are in and not in.
module dr_rail_cell
    import dr_pkg::*;
(
    input  logic  in_bit,
    input  rail_t opp,
    output rail_t nxt
);
    // Proved 1 needs input 1 and opposite proved 0; proved 0 needs either cause.
    always_comb begin
        nxt.t = in_bit & opp.f;
        nxt.f = ~in_bit | opp.t;
    end
endmodule

// File: rtl/dr_rail_bank.sv
// Module: input capture and proof-flag registers for all loop signals.
// What it does: on load, captures inputs and clears flags; on step, writes
// every flag from the cells at once; reports whether a step changes anything.
// Assumes: load and step are never high together (controller guarantees).
module dr_rail_bank
    import dr_pkg::*;
#(
    parameter int N = NSIG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [N-1:0]      in_bits,
    output rail_t [N-1:0]     rails,
    output logic              changed,
    output logic              both_set
);
    logic  [N-1:0] in_q;
    rail_t [N-1:0] rail_q;
    rail_t [N-1:0] rail_nxt;

    // One cell per signal; each reads the flags of its opposite partner.
    generate
        for (genvar k = 0; k < N; k++) begin : g_cell
            dr_rail_cell u_cell (
                .in_bit (in_q[k]),
                .opp    (rail_q[N-1-k]),
                .nxt    (rail_nxt[k])
            );
        end
    endgenerate

    // Capture inputs on load; the held copy feeds the cells during a run.
    always_ff @(posedge clk) begin
        if (!rst_n)    in_q <= '0;
        else if (load) in_q <= in_bits;
    end

    // Flag registers: cleared on load, all written together on step.
    always_ff @(posedge clk) begin
        if (!rst_n)      rail_q <= '0;
        else if (load)   rail_q <= '0;
        else if (step)   rail_q <= rail_nxt;
    end

    // Quiescence and conflict detection over every signal.
    always_comb begin
        changed  = (rail_nxt != rail_q);
        both_set = 1'b0;
        for (int k = 0; k < N; k++) begin
            both_set = both_set | (rail_q[k].t & rail_q[k].f);
        end
    end

    assign rails = rail_q;

    // R2: a load leaves every flag cleared.
    p_clear_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rails == '0));

    // R4: without a load, no flag that was set may clear.
    p_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((rails & $past(rails)) == $past(rails)));

    // R10: no signal ever carries both proofs.
    p_no_conflict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !both_set);
endmodule

// File: rtl/dr_seq_ctrl.sv
// Module: run controller for the fixpoint iteration.
// What it does: accepts start when not running, steps until the bank
// reports no change, then holds the done state until the next start.
// Assumes: 'changed' is valid every cycle in the run state.
module dr_seq_ctrl
    import dr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic changed,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    ev_state_e state_q;

    // Start is only taken outside a run; a pulse during a run is dropped.
    assign load = start && (state_q != ST_RUN);
    assign step = (state_q == ST_RUN);
    assign busy = (state_q == ST_RUN);
    assign done = (state_q == ST_DONE);

    // State register: idle/done -> run on start, run -> done when quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_RUN;
                ST_RUN:  if (!changed) state_q <= ST_DONE;
                ST_DONE: if (start) state_q <= ST_RUN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: a start during a run with progress left keeps the run going.
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && changed) |=> busy);

    // R8: done holds until a start arrives.
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R2: an accepted start always enters the run state.
    p_start_enters_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

    // R8: done and busy are never high together.
    p_state_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

// File: rtl/dr_loop_eval.sv
// Module: top of the dual-rail evaluator for X = I & ~Y, Y = J & ~X.
// What it does: ties controller and flag bank, exposes flags and flags
// done, constructive (all resolved) and a conflict indicator.
// Assumes: in_i/in_j are sampled only on the edge that accepts start.
module dr_loop_eval
    import dr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_i,
    input  logic in_j,
    output logic x_t,
    output logic x_f,
    output logic y_t,
    output logic y_f,
    output logic busy,
    output logic done,
    output logic constructive,
    output logic rail_err
);
    localparam int IDX_X = 0;
    localparam int IDX_Y = NSIG - 1;

    logic          load;
    logic          step;
    logic          changed;
    logic          both_set;
    rail_t [NSIG-1:0] rails;

    dr_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .changed (changed),
        .load    (load),
        .step    (step),
        .busy    (busy),
        .done    (done)
    );

    dr_rail_bank #(.N(NSIG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .in_bits  ({in_j, in_i}),
        .rails    (rails),
        .changed  (changed),
        .both_set (both_set)
    );

    // Resolved means exactly one flag per signal, reported only once done.
    always_comb begin
        constructive = done;
        for (int k = 0; k < NSIG; k++) begin
            constructive = constructive & (rails[k].t ^ rails[k].f);
        end
    end

    assign x_t      = rails[IDX_X].t;
    assign x_f      = rails[IDX_X].f;
    assign y_t      = rails[IDX_Y].t;
    assign y_f      = rails[IDX_Y].f;
    assign rail_err = both_set;

    // R8: once done without a start, the flags stay put.
    p_done_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable({x_t, x_f, y_t, y_f}));

    // R7: both inputs high can never prove X or Y.
    p_no_proof_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_i && in_j) |=> (!x_t && !x_f && !y_t && !y_f));
endmodule

// File: tb/dr_loop_eval_tb.sv
// Bench: drives start/inputs at negedges, steps a three-valued integer
// model at each posedge and compares all outputs at every negedge.
module dr_loop_eval_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_i = 1'b0;
    logic in_j = 1'b0;
    logic x_t, x_f, y_t, y_f, busy, done, constructive, rail_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    dr_loop_eval dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_i(in_i), .in_j(in_j),
        .x_t(x_t), .x_f(x_f), .y_t(y_t), .y_f(y_f),
        .busy(busy), .done(done), .constructive(constructive), .rail_err(rail_err)
    );

    // Model: values 0, 1, 2 (=unknown); state 0 idle, 1 run, 2 done.
    int m_x = 2, m_y = 2, m_i = 0, m_j = 0, m_st = 0;

    function automatic int t_not(input int a);
        return (a == 2) ? 2 : 1 - a;
    endfunction
    function automatic int t_and(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        if (a == 1 && b == 1) return 1;
        return 2;
    endfunction

    // Model stepping per clock edge (R2, R3, R8, R9).
    always @(posedge clk) begin
        int nx, ny;
        if (!rst_n) begin
            m_x = 2; m_y = 2; m_i = 0; m_j = 0; m_st = 0;
        end else if (m_st == 1) begin
            nx = t_and(m_i, t_not(m_y));
            ny = t_and(m_j, t_not(m_x));
            if (nx == m_x && ny == m_y) m_st = 2;
            m_x = nx; m_y = ny;
        end else if (start) begin
            m_i = int'(in_i); m_j = int'(in_j);
            m_x = 2; m_y = 2; m_st = 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model (R3 flags, R8 status, R10).
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R3 flags", {x_t, x_f, y_t, y_f},
                {m_x == 1, m_x == 0, m_y == 1, m_y == 0});
            chk("R8 busy/done", {busy, done}, {m_st == 1, m_st == 2});
            chk("R7 constructive", constructive,
                (m_st == 2) && m_x != 2 && m_y != 2);
            chk("R10 rail_err", rail_err, 1'b0);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    // Pulse start with the given inputs; return edges until done.
    task automatic run_case(input logic i, input logic j, output int lat);
        @(negedge clk);
        start = 1'b1; in_i = i; in_j = j;
        @(negedge clk);
        start = 1'b0;
        chk("R2 cleared after start", {busy, x_t, x_f, y_t, y_f}, 5'b10000);
        lat = 0;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        chk("R1 reset state", {x_t, x_f, y_t, y_f, busy, done, constructive, rail_err}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {busy, done}, 2'b00);

        run_case(1'b0, 1'b1, lat);
        chk("R5 X=0 Y=1", {x_t, x_f, y_t, y_f, constructive}, 5'b01101);
        chk("R8 latency (0,1)", lat, 3);

        run_case(1'b1, 1'b0, lat);
        chk("R6 X=1 Y=0", {x_t, x_f, y_t, y_f, constructive}, 5'b10011);
        chk("R8 latency (1,0)", lat, 3);

        run_case(1'b1, 1'b1, lat);
        chk("R7 unknown both", {x_t, x_f, y_t, y_f, done, constructive}, 6'b000010);
        chk("R8 latency (1,1)", lat, 1);

        run_case(1'b0, 1'b0, lat);
        chk("R11 X=0 Y=0", {x_t, x_f, y_t, y_f, constructive}, 5'b01011);
        chk("R8 latency (0,0)", lat, 2);

        // R8: results held for many cycles with inputs wiggling.
        in_i = 1'b1; in_j = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 hold", {x_t, x_f, y_t, y_f, done, constructive}, 6'b010111);

        // R9: start mid-run with other inputs is ignored.
        @(negedge clk);
        start = 1'b1; in_i = 1'b0; in_j = 1'b1;
        @(negedge clk);
        in_i = 1'b1; in_j = 1'b0;           // busy now, pulse still high
        @(negedge clk);
        start = 1'b0; in_i = 1'b0; in_j = 1'b0;
        lat = 0;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 start ignored", {x_t, x_f, y_t, y_f, constructive}, 5'b01101);

        // R4: flags only accumulate during a run (checked via the model trace).
        run_case(1'b1, 1'b0, lat);
        chk("R4 final set", {x_t, y_f}, 2'b11);

        // R1: reset mid-result clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset again", {x_t, x_f, y_t, y_f, busy, done, constructive}, 7'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule